// File: doc/BRIEF.md
# Interrupt Remapping Table Pointer Register Block

This block is the software-visible control slice of an interrupt-remapping unit. It holds a write-only global command register, a read-only global status register and a 64-bit remapping-table address register. A simple request bus reaches all three. Each request carries an offset, 64 bits of write data and a width flag that selects a 32-bit or a 64-bit access. Reads are combinational, and writes take effect at the clock edge that samples them.

A command write is evaluated against the current status. The status is first masked with 0x96FFFFFF, which clears the one-shot positions 30, 29, 27 and 24. The masked value is XORed with the written word, and the result is the set of fields the command changes. If the table-pointer field (bit 24) is among them and is also set in the written word, the block copies three values from the address register: the 4 KB-aligned table base, the entry count and the extended-mode flag. It then sets status bit 24. The copied values drive downstream translation logic and stay unchanged until the next pointer command.

Top module: `irq_remap_regs`

## Requirements
- R1: After reset, every register reads as zero, and the outputs tab_valid, tab_base, tab_entries, tab_ext and multi_update are all zero.
- R2: The address register can be written as two 32-bit halves: the low half at OFS_TAB (default 0x08) and the high half at OFS_TAB+4, each taken from req_wdata[31:0]. It can also be written as one 64-bit access at OFS_TAB. A 32-bit read of either half returns that half in rd_data[31:0] with the upper bits zero. A 64-bit read at OFS_TAB returns the whole register.
- R3: A write is ignored and completes without effect when it is misaligned, meaning a 32-bit access with offset bits 1:0 nonzero or a 64-bit access with offset bits 2:0 nonzero.
- R4: The command register at OFS_CMD (default 0x00) reads as zero. The status register at OFS_STS (default 0x04) is read-only, and writes to it change nothing. A command write is a 32-bit access at OFS_CMD.
- R5: The change vector is (status AND 0x96FFFFFF) XOR the written command. A command write whose change vector is zero has no effect.
- R6: When change bit 24 and written bit 24 are both set, the block latches three values at that write's clock edge. tab_base takes address bits 63:12. tab_entries takes 2^(S+1), where S is address bits 3:0. tab_ext takes address bit 11. tab_valid goes high and stays high.
- R7: After a pointer latch, status bit 24 is set and reads back at OFS_STS as 0x01000000.
- R8: When the change vector has more than one bit set, multi_update is high for exactly the one cycle after the write. The pointer field is still processed in that case.
- R9: The latched outputs hold their values while the address register is rewritten, until the next pointer command.
- R10: A command write with bit 24 clear does not latch, even when other fields change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| req_offset | input | OFS_W | Byte offset of the access |
| req_wdata | input | 64 | Write data; 32-bit writes use bits 31:0 |
| rd_data | output | 64 | Combinational read data |
| tab_valid | output | 1 | A table pointer has been latched |
| tab_base | output | 52 | Latched table base (address bits 63:12) |
| tab_entries | output | 2**SIZE_W+1 | Latched entry count |
| tab_ext | output | 1 | Latched extended-mode flag |
| multi_update | output | 1 | One-cycle pulse after a command write that changes more than one field |

## Verification
The bench uses the default parameters: SIZE_W of 4 and offsets 0x00, 0x04 and 0x08. A 4-bit size field makes the largest encoding, S = 15, directly reachable, so the 17-bit entry count of 65536 is exercised along with a small count of 16. The same defaults place the high half of the address register at 0x0C. That offset is 32-bit aligned but not 64-bit aligned, so one offset exercises both the accepted half write and the rejected misaligned 64-bit write.

// File: rtl/irq_remap_pkg.sv
package irq_remap_pkg;
  localparam int unsigned CMD_W    = 32;
  localparam int unsigned REG_W    = 64;
  localparam int unsigned PTR_BIT  = 24;
  localparam logic [CMD_W-1:0] ONE_SHOT_KEEP = 32'h96FF_FFFF;
  localparam int unsigned PAGE_SH  = 12;
  localparam int unsigned EXT_BIT  = 11;
  localparam int unsigned BASE_W   = REG_W - PAGE_SH;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CMD,
    SEL_STS,
    SEL_TAB_LO,
    SEL_TAB_HI,
    SEL_TAB_FULL
  } rd_sel_e;
endpackage

// File: rtl/irq_remap_bus_dec.sv
module irq_remap_bus_dec
  import irq_remap_pkg::*;
#(
  parameter int unsigned OFS_W   = 8,
  parameter int unsigned OFS_CMD = 0,
  parameter int unsigned OFS_STS = 4,
  parameter int unsigned OFS_TAB = 8
) (
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_wide,
  input  logic [OFS_W-1:0] req_offset,
  output logic             wr_cmd,
  output logic             wr_tab_lo,
  output logic             wr_tab_hi,
  output logic             wr_tab_full,
  output rd_sel_e          rd_sel
);
  localparam logic [OFS_W-1:0] A_CMD = OFS_W'(OFS_CMD);
  localparam logic [OFS_W-1:0] A_STS = OFS_W'(OFS_STS);
  localparam logic [OFS_W-1:0] A_LO  = OFS_W'(OFS_TAB);
  localparam logic [OFS_W-1:0] A_HI  = OFS_W'(OFS_TAB + 4);

  logic ok32, ok64, hit_cmd, hit_sts, hit_lo, hit_hi;

  always_comb begin
    ok32    = req_valid && !req_wide && (req_offset[1:0] == 2'b00);
    ok64    = req_valid &&  req_wide && (req_offset[2:0] == 3'b000);
    hit_cmd = (req_offset == A_CMD);
    hit_sts = (req_offset == A_STS);
    hit_lo  = (req_offset == A_LO);
    hit_hi  = (req_offset == A_HI);

    wr_cmd      = req_write && ok32 && hit_cmd;
    wr_tab_lo   = req_write && ok32 && hit_lo;
    wr_tab_hi   = req_write && ok32 && hit_hi;
    wr_tab_full = req_write && ok64 && hit_lo;

    rd_sel = SEL_NONE;
    if (!req_write) begin
      if (ok32 && hit_cmd)     rd_sel = SEL_CMD;
      else if (ok32 && hit_sts) rd_sel = SEL_STS;
      else if (ok32 && hit_lo)  rd_sel = SEL_TAB_LO;
      else if (ok32 && hit_hi)  rd_sel = SEL_TAB_HI;
      else if (ok64 && hit_lo)  rd_sel = SEL_TAB_FULL;
    end
  end
endmodule

// File: rtl/irq_remap_tab_reg.sv
module irq_remap_tab_reg
  import irq_remap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic             wr_full,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] tab_q
);
  localparam int unsigned HALF = REG_W / 2;

  logic [REG_W-1:0] tab_d;
  logic             tab_en;

  always_comb begin
    tab_en = wr_lo || wr_hi || wr_full;
    tab_d  = tab_q;
    if (wr_full)    tab_d = wdata;
    else if (wr_lo) tab_d[HALF-1:0]     = wdata[HALF-1:0];
    else if (wr_hi) tab_d[REG_W-1:HALF] = wdata[HALF-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tab_q <= '0;
    else if (tab_en) tab_q <= tab_d;
  end
endmodule

// File: rtl/irq_remap_cmd_eval.sv
module irq_remap_cmd_eval
  import irq_remap_pkg::*;
(
  input  logic             wr_cmd,
  input  logic [CMD_W-1:0] sts,
  input  logic [CMD_W-1:0] cmd,
  output logic             multi,
  output logic             do_ptr
);
  logic [CMD_W-1:0] delta;

  always_comb begin
    delta  = (sts & ONE_SHOT_KEEP) ^ cmd;
    multi  = wr_cmd && ((delta & (delta - CMD_W'(1))) != '0);
    do_ptr = wr_cmd && delta[PTR_BIT] && cmd[PTR_BIT];
  end
endmodule

// File: rtl/irq_remap_tab_latch.sv
module irq_remap_tab_latch
  import irq_remap_pkg::*;
#(
  parameter int unsigned SIZE_W = 4,
  localparam int unsigned CNT_W = (1 << SIZE_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              do_ptr,
  input  logic [BASE_W-1:0] src_base,
  input  logic [SIZE_W-1:0] src_size,
  input  logic              src_ext,
  output logic              lat_valid,
  output logic [BASE_W-1:0] lat_base,
  output logic [CNT_W-1:0]  lat_entries,
  output logic              lat_ext
);
  localparam int unsigned SH_W = SIZE_W + 1;

  logic [SH_W-1:0]  shamt;
  logic [CNT_W-1:0] entries_d;

  always_comb begin
    shamt     = SH_W'(src_size) + SH_W'(1);
    entries_d = CNT_W'(1) << shamt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_valid   <= 1'b0;
      lat_base    <= '0;
      lat_entries <= '0;
      lat_ext     <= 1'b0;
    end else if (do_ptr) begin
      lat_valid   <= 1'b1;
      lat_base    <= src_base;
      lat_entries <= entries_d;
      lat_ext     <= src_ext;
    end
  end
endmodule

// File: rtl/irq_remap_regs.sv
module irq_remap_regs
  import irq_remap_pkg::*;
#(
  parameter int unsigned OFS_W   = 8,
  parameter int unsigned OFS_CMD = 0,
  parameter int unsigned OFS_STS = 4,
  parameter int unsigned OFS_TAB = 8,
  parameter int unsigned SIZE_W  = 4,
  localparam int unsigned CNT_W  = (1 << SIZE_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_wide,
  input  logic [OFS_W-1:0]  req_offset,
  input  logic [63:0]       req_wdata,
  output logic [63:0]       rd_data,
  output logic              tab_valid,
  output logic [51:0]       tab_base,
  output logic [CNT_W-1:0]  tab_entries,
  output logic              tab_ext,
  output logic              multi_update
);
  localparam int unsigned HALF = REG_W / 2;

  logic             wr_cmd, wr_tab_lo, wr_tab_hi, wr_tab_full;
  rd_sel_e          rd_sel;
  logic [REG_W-1:0] tab_q;
  logic [CMD_W-1:0] sts_q, sts_d;
  logic             multi, do_ptr, multi_q;

  irq_remap_bus_dec #(
    .OFS_W(OFS_W), .OFS_CMD(OFS_CMD), .OFS_STS(OFS_STS), .OFS_TAB(OFS_TAB)
  ) u_dec (
    .req_valid(req_valid), .req_write(req_write), .req_wide(req_wide),
    .req_offset(req_offset), .wr_cmd(wr_cmd), .wr_tab_lo(wr_tab_lo),
    .wr_tab_hi(wr_tab_hi), .wr_tab_full(wr_tab_full), .rd_sel(rd_sel)
  );

  irq_remap_tab_reg u_tab (
    .clk(clk), .rst_n(rst_n), .wr_lo(wr_tab_lo), .wr_hi(wr_tab_hi),
    .wr_full(wr_tab_full), .wdata(req_wdata), .tab_q(tab_q)
  );

  irq_remap_cmd_eval u_eval (
    .wr_cmd(wr_cmd), .sts(sts_q), .cmd(req_wdata[CMD_W-1:0]),
    .multi(multi), .do_ptr(do_ptr)
  );

  irq_remap_tab_latch #(.SIZE_W(SIZE_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .do_ptr(do_ptr),
    .src_base(tab_q[REG_W-1:PAGE_SH]), .src_size(tab_q[SIZE_W-1:0]),
    .src_ext(tab_q[EXT_BIT]), .lat_valid(tab_valid), .lat_base(tab_base),
    .lat_entries(tab_entries), .lat_ext(tab_ext)
  );

  // Status: sticky set of the pointer-complete bit
  always_comb begin
    sts_d = sts_q;
    sts_d[PTR_BIT] = sts_q[PTR_BIT] | do_ptr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q   <= '0;
      multi_q <= 1'b0;
    end else begin
      if (do_ptr) sts_q <= sts_d;
      multi_q <= multi;
    end
  end

  assign multi_update = multi_q;

  always_comb begin
    rd_data = '0;
    unique case (rd_sel)
      SEL_STS:      rd_data = {{(64-CMD_W){1'b0}}, sts_q};
      SEL_TAB_LO:   rd_data = {{HALF{1'b0}}, tab_q[HALF-1:0]};
      SEL_TAB_HI:   rd_data = {{HALF{1'b0}}, tab_q[REG_W-1:HALF]};
      SEL_TAB_FULL: rd_data = tab_q;
      default:      rd_data = '0;
    endcase
  end
endmodule

// File: rtl/irq_remap_regs_chk.sv
module irq_remap_regs_chk #(
  parameter int unsigned OFS_W   = 8,
  parameter int unsigned OFS_CMD = 0,
  parameter int unsigned CNT_W   = 17
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_write,
  input logic             req_wide,
  input logic [OFS_W-1:0] req_offset,
  input logic [63:0]      req_wdata,
  input logic [63:0]      rd_data,
  input logic [31:0]      sts,
  input logic             tab_valid,
  input logic [51:0]      tab_base,
  input logic [CNT_W-1:0] tab_entries,
  input logic             tab_ext,
  input logic             multi_update
);
  logic cmd_wr, cmd_rd;
  assign cmd_wr = req_valid && req_write && !req_wide && (req_offset == OFS_W'(OFS_CMD));
  assign cmd_rd = req_valid && !req_write && !req_wide && (req_offset == OFS_W'(OFS_CMD));

  assert_cmd_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rd |-> (rd_data == 64'd0));

  assert_ptr_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && req_wdata[24]) |=> (tab_valid && sts[24]));

  assert_entries_pow2_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tab_valid |-> ($countones(tab_entries) == 1));

  assert_valid_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(tab_valid));

  assert_sts_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[24]) |-> $past(cmd_wr && req_wdata[24]));

  assert_multi_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    multi_update |-> $past(cmd_wr));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_wr && req_wdata[24]) |=>
      ($stable(tab_base) && $stable(tab_entries) && $stable(tab_ext)));
endmodule

bind irq_remap_regs irq_remap_regs_chk #(
  .OFS_W(OFS_W), .OFS_CMD(OFS_CMD), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_wide(req_wide), .req_offset(req_offset), .req_wdata(req_wdata),
  .rd_data(rd_data), .sts(sts_q), .tab_valid(tab_valid), .tab_base(tab_base),
  .tab_entries(tab_entries), .tab_ext(tab_ext), .multi_update(multi_update)
);

// File: tb/test_irq_remap_regs.sv
module test_irq_remap_regs;
  localparam int unsigned OFS_W = 8;
  localparam int unsigned CNT_W = 17;
  localparam logic [7:0] A_CMD = 8'h00, A_STS = 8'h04, A_LO = 8'h08, A_HI = 8'h0C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0;
  logic [OFS_W-1:0] req_offset = '0;
  logic [63:0] req_wdata = '0;
  logic [63:0] rd_data;
  logic tab_valid, tab_ext, multi_update;
  logic [51:0] tab_base;
  logic [CNT_W-1:0] tab_entries;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_remap_regs i_irq_remap_regs (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_wide(req_wide), .req_offset(req_offset), .req_wdata(req_wdata),
    .rd_data(rd_data), .tab_valid(tab_valid), .tab_base(tab_base),
    .tab_entries(tab_entries), .tab_ext(tab_ext), .multi_update(multi_update)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] ofs, input logic wide, input logic [63:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_wide = wide; req_offset = ofs; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_wide = 1'b0; req_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] ofs, input logic wide, output logic [63:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_wide = wide; req_offset = ofs;
    #2 d = rd_data;
    req_valid = 1'b0; req_wide = 1'b0;
  endtask

  task automatic chk_latched(input string tag, input logic [63:0] v);
    chk({tag, " valid"}, 64'(tab_valid), 64'd1);
    chk({tag, " base"}, 64'(tab_base), 64'(v[63:12]));
    chk({tag, " entries"}, 64'(tab_entries), 64'd1 << (int'(v[3:0]) + 1));
    chk({tag, " ext"}, 64'(tab_ext), 64'(v[11]));
  endtask

  task automatic t_reset();
    logic [63:0] d;
    chk("R1 valid", 64'(tab_valid), 0);
    chk("R1 base", 64'(tab_base), 0);
    chk("R1 entries", 64'(tab_entries), 0);
    chk("R1 ext/multi", {62'd0, tab_ext, multi_update}, 0);
    rd(A_STS, 1'b0, d); chk("R1 status", d, 0);
    rd(A_LO, 1'b1, d);  chk("R1 addr reg", d, 0);
  endtask

  task automatic t_halves();
    logic [63:0] d;
    wr(A_LO, 1'b0, 64'h0000_0000_1234_5A07);
    wr(A_HI, 1'b0, 64'h0000_0000_DEAD_BEEF);
    rd(A_LO, 1'b1, d); chk("R2 64b read after halves", d, 64'hDEAD_BEEF_1234_5A07);
    rd(A_HI, 1'b0, d); chk("R2 high half read", d, 64'h0000_0000_DEAD_BEEF);
    rd(A_LO, 1'b0, d); chk("R2 low half read", d, 64'h0000_0000_1234_5A07);
    wr(A_LO, 1'b1, 64'h0000_00AB_CDEF_F803);
    rd(A_LO, 1'b1, d); chk("R2 64b write", d, 64'h0000_00AB_CDEF_F803);
  endtask

  task automatic t_misaligned();
    logic [63:0] d;
    wr(A_LO + 8'd1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(A_HI, 1'b1, 64'h1111_2222_3333_4444);
    rd(A_LO, 1'b1, d); chk("R3 misaligned writes ignored", d, 64'h0000_00AB_CDEF_F803);
    wr(A_CMD + 8'd2, 1'b0, 64'h0100_0000);
    chk("R3 misaligned command ignored", 64'(tab_valid), 0);
  endtask

  task automatic t_ro();
    logic [63:0] d;
    wr(A_STS, 1'b0, 64'hFFFF_FFFF);
    rd(A_STS, 1'b0, d); chk("R4 status write ignored", d, 0);
    rd(A_CMD, 1'b0, d); chk("R4 command reads zero", d, 0);
  endtask

  task automatic t_nochange();
    wr(A_CMD, 1'b0, 64'h0);
    chk("R5 zero change: no latch", 64'(tab_valid), 0);
    chk("R5 zero change: no multi", 64'(multi_update), 0);
  endtask

  task automatic t_latch();
    logic [63:0] d;
    wr(A_CMD, 1'b0, 64'h0100_0000);
    chk_latched("R6 first latch", 64'h0000_00AB_CDEF_F803);
    chk("R8 single change no multi", 64'(multi_update), 0);
    rd(A_STS, 1'b0, d); chk("R7 status bit 24", d, 64'h0100_0000);
    rd(A_CMD, 1'b0, d); chk("R4 command still reads zero", d, 0);
  endtask

  task automatic t_hold();
    wr(A_LO, 1'b1, 64'h1234_5678_9ABC_D00F);
    chk_latched("R9 hold after addr write", 64'h0000_00AB_CDEF_F803);
    wr(A_CMD, 1'b0, 64'h0000_0000);
    chk_latched("R5 masked status gives zero change", 64'h0000_00AB_CDEF_F803);
    wr(A_CMD, 1'b0, 64'h0100_0000);
    chk_latched("R6 relatch max size", 64'h1234_5678_9ABC_D00F);
  endtask

  task automatic t_multi();
    wr(A_LO, 1'b1, 64'h0000_0000_0000_5805);
    wr(A_CMD, 1'b0, 64'h8300_0000);
    chk("R8 multi pulse", 64'(multi_update), 1);
    chk_latched("R8 pointer still processed", 64'h0000_0000_0000_5805);
    @(negedge clk);
    chk("R8 pulse one cycle", 64'(multi_update), 0);
    wr(A_LO, 1'b1, 64'h0000_0000_0000_1002);
    wr(A_CMD, 1'b0, 64'h0200_0000);
    chk_latched("R10 no bit 24 no latch", 64'h0000_0000_0000_5805);
    chk("R10 single change no multi", 64'(multi_update), 0);
  endtask

  initial begin
    #20;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_halves();
    t_misaligned();
    t_ro();
    t_nochange();
    t_latch();
    t_hold();
    t_multi();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule